// File: doc/BRIEF.md
# Conversion Sequencer Halt Controller

This block decides when a queued conversion sequencer must stop for a debug halt or a low-power stop, and what the rest of the converter may do while it is halted. It watches a debug freeze request (qualified by a freeze-enable bit) and a low-power stop request (qualified by a stop-enable bit). It also watches the sequencer's queue-busy, conversion-done, mode-change and second-queue-abort status, and the sequencer's command-word pointer. From these it drives a halt to the sequencer and holds resets on the analog logic, the periodic timer and the conversion clock prescaler. It also gates the capture of external trigger edges, records the pointer of the interrupted command word, and grants or refuses register and table accesses by register group.

A freeze request that arrives while the queue is busy waits for the current conversion to finish. A mode change on the active queue or an abort of the second queue ends that wait at once. Stop takes precedence over freeze. While stopped, the control/status group is forced to reset and each register group gets its own access rights.

Top module: `qseq_halt_ctrl`

## Requirements
- R1: With freeze enabled, a freeze request while the queue is idle puts the block in the frozen state with the sequencer halt asserted after the next clock edge.
- R2: A freeze request while the queue is busy leaves the sequencer running until conversion-done is seen. Halt is asserted after the edge that samples conversion-done.
- R3: While a freeze is waiting for a busy conversion, a mode-change or second-queue-abort indication asserts halt after the next edge, without waiting for conversion-done.
- R4: A freeze request has no effect while freeze-enable is 0. A stop request has no effect while stop-enable is 0, and table reads and writes stay granted in that case.
- R5: On entry to the frozen state, if the queue was busy, `saved_ptr` takes the value of `qptr` sampled at that edge and `ptr_valid` is 1. If the queue was idle, `ptr_valid` is 0.
- R6: While frozen, `timer_rst` and `analog_rst` are 1 and `prescale_rst` is 0.
- R7: A rising edge on a `trig_in` bit sets the matching `trig_pending` bit unless the block is frozen or stopped, in which case the edge is discarded. A 1 on `trig_ack` clears the matching pending bit.
- R8: While stopped, `prescale_rst`, `timer_rst`, `analog_rst`, `ctrl_grp_rst` and `seq_halt` are all 1.
- R9: While stopped, access rights depend on `acc_grp`. Group 0 (configuration/interrupt/test) may be read and written. Groups 1 (direction/port data) and 2 (control/status) may be read only. Group 3 (command and result tables) may be neither read nor written. Outside stop, every group may be read and written.
- R10: A refused read returns 0 on `acc_rd_out`. A refused write leaves `acc_wr_ok` at 0. A granted read passes `acc_rd_data` through.
- R11: When the freeze or stop request drops, every held reset and the halt are released after the next edge. Leaving freeze raises `resume` for exactly one cycle.
- R12: With both a stop request and a freeze request enabled, the block is stopped, not frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_en | input | 1 | Low-power stop enable bit |
| stop_req | input | 1 | Low-power stop request |
| frz_en | input | 1 | Freeze enable bit |
| dbg_freeze | input | 1 | Debug freeze request line |
| queue_busy | input | 1 | A queue is executing |
| conv_done | input | 1 | Current conversion completes this cycle |
| mode_change | input | 1 | Active queue's operating mode changed |
| q2_abort | input | 1 | Second queue aborted |
| qptr | input | PTR_W | Current command-word pointer |
| trig_in | input | N_TRIG | External trigger levels |
| trig_ack | input | N_TRIG | Clear pending trigger |
| acc_grp | input | 2 | Register group of the access (0..3) |
| acc_rd | input | 1 | Read request |
| acc_wr | input | 1 | Write request |
| acc_rd_data | input | DATA_W | Read data from register storage |
| seq_halt | output | 1 | Halt to the sequencer |
| frozen | output | 1 | Frozen state |
| stopped | output | 1 | Stopped state |
| prescale_rst | output | 1 | Conversion clock prescaler reset |
| timer_rst | output | 1 | Periodic/interval timer reset |
| analog_rst | output | 1 | Analog logic reset |
| ctrl_grp_rst | output | 1 | Force control/status group to reset values |
| resume | output | 1 | One-cycle pulse on leaving freeze |
| ptr_valid | output | 1 | Saved pointer is meaningful |
| saved_ptr | output | PTR_W | Pointer captured on freeze entry |
| trig_pending | output | N_TRIG | Latched trigger events |
| acc_rd_ok | output | 1 | Read granted |
| acc_wr_ok | output | 1 | Write granted |
| acc_rd_out | output | DATA_W | Read data, zero when refused |

## Verification
The bench holds a freeze request across a busy conversion and checks that halt stays low until conversion-done. A design that froze at once would halt one or more cycles early. It then ends the same kind of wait with a mode change and with an abort, where a design that ignored those would hang in the waiting state. Trigger edges are raised while frozen and while stopped, so a latch that ignored the gate would show a pending bit. The bench steps through all four register groups while stopped, raises a freeze and a stop together, and clears each enable bit in turn. A swapped priority, a table left open, or an enable that does nothing would each show up on the mode or access outputs.

// File: rtl/qsf_pkg.sv
package qsf_pkg;

  typedef enum logic [1:0] {
    HC_RUN     = 2'd0,
    HC_WAIT    = 2'd1,
    HC_FROZEN  = 2'd2,
    HC_STOPPED = 2'd3
  } hc_state_e;

  typedef enum logic [1:0] {
    GRP_CFG   = 2'd0,
    GRP_PORT  = 2'd1,
    GRP_CTRL  = 2'd2,
    GRP_TABLE = 2'd3
  } acc_grp_e;

  function automatic logic grp_rd_allowed(acc_grp_e g, logic stop_mode);
    return !stop_mode || (g != GRP_TABLE);
  endfunction

  function automatic logic grp_wr_allowed(acc_grp_e g, logic stop_mode);
    return !stop_mode || (g == GRP_CFG);
  endfunction

  function automatic logic state_halts(hc_state_e s);
    return (s == HC_FROZEN) || (s == HC_STOPPED);
  endfunction

  function automatic logic cut_conversion(logic busy, logic done,
                                          logic mode_chg, logic abort2);
    return !busy || done || mode_chg || abort2;
  endfunction

endpackage

// File: rtl/qsf_mode_fsm.sv
module qsf_mode_fsm
  import qsf_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_en,
  input  logic             stop_req,
  input  logic             frz_en,
  input  logic             dbg_freeze,
  input  logic             queue_busy,
  input  logic             conv_done,
  input  logic             mode_change,
  input  logic             q2_abort,
  input  logic [PTR_W-1:0] qptr,
  output hc_state_e        state_o,
  output logic [PTR_W-1:0] saved_ptr,
  output logic             ptr_valid,
  output logic             resume
);

  hc_state_e st, nxt;
  logic freeze_req, stop_eff, cut_now, enter_frozen, leave_frozen;

  assign freeze_req   = dbg_freeze && frz_en;
  assign stop_eff     = stop_req && stop_en;
  assign cut_now      = cut_conversion(queue_busy, conv_done, mode_change, q2_abort);
  assign enter_frozen = (nxt == HC_FROZEN) && (st != HC_FROZEN);
  assign leave_frozen = (st == HC_FROZEN) && (nxt == HC_RUN);

  always_comb begin
    nxt = st;
    unique case (st)
      HC_RUN: begin
        if (stop_eff)        nxt = HC_STOPPED;
        else if (freeze_req) nxt = cut_now ? HC_FROZEN : HC_WAIT;
      end
      HC_WAIT: begin
        if (stop_eff)         nxt = HC_STOPPED;
        else if (!freeze_req) nxt = HC_RUN;
        else if (cut_now)     nxt = HC_FROZEN;
      end
      HC_FROZEN: begin
        if (stop_eff)         nxt = HC_STOPPED;
        else if (!freeze_req) nxt = HC_RUN;
      end
      HC_STOPPED: begin
        if (!stop_eff) nxt = HC_RUN;
      end
      default: nxt = HC_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= HC_RUN;
      saved_ptr <= '0;
      ptr_valid <= 1'b0;
      resume    <= 1'b0;
    end else begin
      st     <= nxt;
      resume <= leave_frozen;
      if (enter_frozen) begin
        ptr_valid <= queue_busy;
        if (queue_busy) saved_ptr <= qptr;
      end
    end
  end

  assign state_o = st;

  // R1
  frz_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HC_RUN && freeze_req && !queue_busy && !stop_eff) |=> (st == HC_FROZEN));

  // R2
  frz_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HC_WAIT && freeze_req && !stop_eff && queue_busy && !conv_done
     && !mode_change && !q2_abort) |=> (st == HC_WAIT));

  // R3
  frz_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HC_WAIT && freeze_req && !stop_eff && (mode_change || q2_abort))
    |=> (st == HC_FROZEN));

  // R4
  frz_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frz_en |=> (st != HC_FROZEN));

  // R4
  stop_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_en |=> (st != HC_STOPPED));

  // R5
  ptr_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st == HC_FROZEN) && $past(queue_busy)) |-> (ptr_valid && saved_ptr == $past(qptr)));

  // R12
  stop_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_eff |=> (st == HC_STOPPED));

endmodule

// File: rtl/qsf_trig_latch.sv
module qsf_trig_latch #(
  parameter int N_TRIG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [N_TRIG-1:0] trig_ack,
  output logic [N_TRIG-1:0] pending
);

  logic [N_TRIG-1:0] prev;
  logic [N_TRIG-1:0] rise;

  for (genvar i = 0; i < N_TRIG; i++) begin : g_trig
    assign rise[i] = trig_in[i] && !prev[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev[i]    <= 1'b0;
        pending[i] <= 1'b0;
      end else begin
        prev[i]    <= trig_in[i];
        pending[i] <= (pending[i] && !trig_ack[i]) || (rise[i] && cap_en);
      end
    end

    // R7
    no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_en && !pending[i]) |=> !pending[i]);

    // R7
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_ack[i] && !(rise[i] && cap_en)) |=> !pending[i]);
  end

endmodule

// File: rtl/qsf_access_gate.sv
module qsf_access_gate
  import qsf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_mode,
  input  logic [1:0]        acc_grp,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] acc_rd_data,
  output logic              acc_rd_ok,
  output logic              acc_wr_ok,
  output logic [DATA_W-1:0] acc_rd_out
);

  acc_grp_e grp;
  logic     rd_allow, wr_allow;

  assign grp        = acc_grp_e'(acc_grp);
  assign rd_allow   = grp_rd_allowed(grp, stop_mode);
  assign wr_allow   = grp_wr_allowed(grp, stop_mode);
  assign acc_rd_ok  = acc_rd && rd_allow;
  assign acc_wr_ok  = acc_wr && wr_allow;
  assign acc_rd_out = acc_rd_ok ? acc_rd_data : '0;

  // R9
  tbl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && acc_grp == 2'd3) |-> (!acc_rd_ok && !acc_wr_ok));

  // R9
  ctrl_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && acc_grp != 2'd0) |-> !acc_wr_ok);

  // R10
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd_ok |-> (acc_rd_out == '0));

endmodule

// File: rtl/qseq_halt_ctrl.sv
module qseq_halt_ctrl
  import qsf_pkg::*;
#(
  parameter int PTR_W  = 4,
  parameter int N_TRIG = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_en,
  input  logic              stop_req,
  input  logic              frz_en,
  input  logic              dbg_freeze,
  input  logic              queue_busy,
  input  logic              conv_done,
  input  logic              mode_change,
  input  logic              q2_abort,
  input  logic [PTR_W-1:0]  qptr,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [N_TRIG-1:0] trig_ack,
  input  logic [1:0]        acc_grp,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] acc_rd_data,
  output logic              seq_halt,
  output logic              frozen,
  output logic              stopped,
  output logic              prescale_rst,
  output logic              timer_rst,
  output logic              analog_rst,
  output logic              ctrl_grp_rst,
  output logic              resume,
  output logic              ptr_valid,
  output logic [PTR_W-1:0]  saved_ptr,
  output logic [N_TRIG-1:0] trig_pending,
  output logic              acc_rd_ok,
  output logic              acc_wr_ok,
  output logic [DATA_W-1:0] acc_rd_out
);

  hc_state_e state;
  logic      halted, cap_en;

  qsf_mode_fsm #(.PTR_W(PTR_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_en    (stop_en),
    .stop_req   (stop_req),
    .frz_en     (frz_en),
    .dbg_freeze (dbg_freeze),
    .queue_busy (queue_busy),
    .conv_done  (conv_done),
    .mode_change(mode_change),
    .q2_abort   (q2_abort),
    .qptr       (qptr),
    .state_o    (state),
    .saved_ptr  (saved_ptr),
    .ptr_valid  (ptr_valid),
    .resume     (resume)
  );

  assign halted       = state_halts(state);
  assign frozen       = (state == HC_FROZEN);
  assign stopped      = (state == HC_STOPPED);
  assign seq_halt     = halted;
  assign timer_rst    = halted;
  assign analog_rst   = halted;
  assign prescale_rst = stopped;
  assign ctrl_grp_rst = stopped;
  assign cap_en       = !halted;

  qsf_trig_latch #(.N_TRIG(N_TRIG)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .trig_in (trig_in),
    .trig_ack(trig_ack),
    .pending (trig_pending)
  );

  qsf_access_gate #(.DATA_W(DATA_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_mode  (stopped),
    .acc_grp    (acc_grp),
    .acc_rd     (acc_rd),
    .acc_wr     (acc_wr),
    .acc_rd_data(acc_rd_data),
    .acc_rd_ok  (acc_rd_ok),
    .acc_wr_ok  (acc_wr_ok),
    .acc_rd_out (acc_rd_out)
  );

  // R6
  frz_clk_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> (!prescale_rst && timer_rst && analog_rst));

  // R8
  stop_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (prescale_rst && timer_rst && ctrl_grp_rst && seq_halt));

  // R11
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (!seq_halt && $past(frozen)));

endmodule

// File: tb/qseq_halt_ctrl_bench.sv
module qseq_halt_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PTR_W = 4, N_TRIG = 2, DATA_W = 8;
  localparam int OW = 25;

  localparam logic [OW-1:0] M_MODE = 25'h7F;
  localparam logic [OW-1:0] M_RES  = 25'h1 << 7;
  localparam logic [OW-1:0] M_PTRV = 25'h1 << 8;
  localparam logic [OW-1:0] M_PTR  = 25'hF << 9;
  localparam logic [OW-1:0] M_TRIG = 25'h3 << 13;
  localparam logic [OW-1:0] M_ACC  = 25'h3FF << 15;

  logic clk = 0, rst_n = 0;
  logic stop_en = 0, stop_req = 0, frz_en = 0, dbg_freeze = 0;
  logic queue_busy = 0, conv_done = 0, mode_change = 0, q2_abort = 0;
  logic [PTR_W-1:0] qptr = '0;
  logic [N_TRIG-1:0] trig_in = '0, trig_ack = '0;
  logic [1:0] acc_grp = '0;
  logic acc_rd = 0, acc_wr = 0;
  logic [DATA_W-1:0] acc_rd_data = '0;
  logic seq_halt, frozen, stopped, prescale_rst, timer_rst, analog_rst, ctrl_grp_rst;
  logic resume, ptr_valid, acc_rd_ok, acc_wr_ok;
  logic [PTR_W-1:0] saved_ptr;
  logic [N_TRIG-1:0] trig_pending;
  logic [DATA_W-1:0] acc_rd_out;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    string           tag;
    logic [OW-1:0]   mask;
    logic [OW-1:0]   val;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  qseq_halt_ctrl #(.PTR_W(PTR_W), .N_TRIG(N_TRIG), .DATA_W(DATA_W)) u_qseq_halt_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_en(stop_en), .stop_req(stop_req),
    .frz_en(frz_en), .dbg_freeze(dbg_freeze), .queue_busy(queue_busy),
    .conv_done(conv_done), .mode_change(mode_change), .q2_abort(q2_abort),
    .qptr(qptr), .trig_in(trig_in), .trig_ack(trig_ack), .acc_grp(acc_grp),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_rd_data(acc_rd_data),
    .seq_halt(seq_halt), .frozen(frozen), .stopped(stopped),
    .prescale_rst(prescale_rst), .timer_rst(timer_rst), .analog_rst(analog_rst),
    .ctrl_grp_rst(ctrl_grp_rst), .resume(resume), .ptr_valid(ptr_valid),
    .saved_ptr(saved_ptr), .trig_pending(trig_pending), .acc_rd_ok(acc_rd_ok),
    .acc_wr_ok(acc_wr_ok), .acc_rd_out(acc_rd_out)
  );

  function automatic logic [OW-1:0] observe();
    return {acc_rd_out, acc_wr_ok, acc_rd_ok, trig_pending, saved_ptr, ptr_valid,
            resume, ctrl_grp_rst, analog_rst, timer_rst, prescale_rst,
            stopped, frozen, seq_halt};
  endfunction

  // mode field: halt, frozen, stopped, prescaler, timer, analog, ctrl group
  function automatic logic [OW-1:0] mv(logic h, logic f, logic s, logic p,
                                       logic t, logic a, logic c);
    return {18'd0, c, a, t, p, s, f, h};
  endfunction

  localparam logic [OW-1:0] V_FRZ  = {18'd0, 7'b0110011};
  localparam logic [OW-1:0] V_STOP = {18'd0, 7'b1111101};

  function automatic logic [OW-1:0] acc_v(logic rd, logic wr, logic [DATA_W-1:0] d);
    return {d, wr, rd, 15'd0};
  endfunction

  task automatic expect_next(string tag, logic [OW-1:0] mask, logic [OW-1:0] val);
    exp_t e;
    e.tag = tag; e.mask = mask; e.val = val;
    sb.push_back(e);
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // monitor: compares one pushed item after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        logic [OW-1:0] o;
        e = sb.pop_front();
        o = observe();
        checks++;
        if (((o ^ e.val) & e.mask) != '0) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h (mask %h)", e.tag,
                   o & e.mask, e.val & e.mask, e.mask);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    expect_next("R11 reset state", M_MODE | M_RES | M_PTRV | M_TRIG, '0);
    cyc();
    rst_n = 1;
    cyc();

    // R1 R6: idle freeze
    frz_en = 1; dbg_freeze = 1; queue_busy = 0;
    expect_next("R1 R6 idle freeze", M_MODE, V_FRZ);
    cyc();
    expect_next("R5 idle entry no pointer", M_PTRV, '0);
    cyc();
    trig_in = 2'b01;
    expect_next("R7 edge while frozen", M_TRIG, '0);
    cyc();
    trig_in = 2'b00;
    cyc();
    dbg_freeze = 0;
    expect_next("R11 freeze release", M_MODE | M_RES, M_RES);
    cyc();
    expect_next("R11 resume single", M_RES, '0);
    cyc();

    // R4: freeze disabled
    frz_en = 0; dbg_freeze = 1;
    expect_next("R4 freeze ignored", M_MODE, '0);
    cyc();
    expect_next("R4 freeze ignored later", M_MODE, '0);
    cyc();
    dbg_freeze = 0; frz_en = 1;
    cyc();

    // R2: busy queue waits for conversion-done
    queue_busy = 1; qptr = 4'd5; dbg_freeze = 1;
    expect_next("R2 waiting", M_MODE, '0);
    cyc();
    trig_in = 2'b01;
    expect_next("R7 capture while waiting", M_MODE | M_TRIG, 25'h1 << 13);
    cyc();
    trig_in = 2'b00; qptr = 4'd6; conv_done = 1;
    expect_next("R2 R5 halt after done", M_MODE | M_PTRV | M_PTR,
                V_FRZ | M_PTRV | (25'd6 << 9));
    cyc();
    conv_done = 0; trig_ack = 2'b01;
    expect_next("R7 ack clears", M_TRIG, '0);
    cyc();
    trig_ack = 2'b00; trig_in = 2'b10;
    expect_next("R7 second edge frozen", M_TRIG, '0);
    cyc();
    trig_in = 2'b00; dbg_freeze = 0;
    expect_next("R11 release after busy freeze", M_MODE, '0);
    cyc();

    // R3: mode change ends wait
    qptr = 4'd9; dbg_freeze = 1;
    expect_next("R3 waiting", M_MODE, '0);
    cyc();
    mode_change = 1; qptr = 4'd10;
    expect_next("R3 mode change cut", M_MODE | M_PTR, V_FRZ | (25'd10 << 9));
    cyc();
    mode_change = 0; dbg_freeze = 0;
    cyc(); cyc();
    dbg_freeze = 1;
    expect_next("R3 waiting again", M_MODE, '0);
    cyc();
    q2_abort = 1;
    expect_next("R3 abort cut", M_MODE, V_FRZ);
    cyc();
    q2_abort = 0; dbg_freeze = 0; queue_busy = 0;
    cyc();

    // R8 R9 R10: stop mode
    stop_en = 1; stop_req = 1; acc_grp = 2'd0; acc_rd = 1; acc_wr = 1; acc_rd_data = 8'hA5;
    expect_next("R8 R9 stop cfg group", M_MODE | M_ACC, V_STOP | acc_v(1, 1, 8'hA5));
    cyc();
    acc_grp = 2'd1;
    expect_next("R9 port group read only", M_ACC, acc_v(1, 0, 8'hA5));
    cyc();
    acc_grp = 2'd2; acc_rd_data = 8'h3C;
    expect_next("R9 control group read only", M_ACC, acc_v(1, 0, 8'h3C));
    cyc();
    acc_grp = 2'd3;
    expect_next("R10 table refused", M_ACC, acc_v(0, 0, 8'h00));
    cyc();
    trig_in = 2'b11;
    expect_next("R7 edge while stopped", M_TRIG, '0);
    cyc();
    trig_in = 2'b00; dbg_freeze = 1;
    expect_next("R12 stop over freeze", M_MODE, V_STOP);
    cyc();
    dbg_freeze = 0; stop_req = 0;
    expect_next("R11 stop release", M_MODE | M_ACC, acc_v(1, 1, 8'h3C));
    cyc();

    // R12 from running with both requests at once
    stop_req = 1; dbg_freeze = 1;
    expect_next("R12 simultaneous requests", M_MODE, V_STOP);
    cyc();
    stop_req = 0; dbg_freeze = 0;
    cyc();

    // R4: stop disabled
    stop_en = 0; stop_req = 1; acc_grp = 2'd3;
    expect_next("R4 stop ignored", M_MODE | M_ACC, acc_v(1, 1, 8'h3C));
    cyc();
    stop_req = 0;
    cyc(); cyc();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule